// File: doc/BRIEF.md
# Peripheral Clock-Enable and Reset Sequencer

This block brings a single peripheral up or down in a safe order. When an enable request arrives and the peripheral does not already report itself as enabled, the sequencer issues a one-cycle command to put the peripheral into reset. It then waits a programmable number of cycles, issues a one-cycle command to start the peripheral's clock, waits a second programmable interval, and finally issues a one-cycle command to take the peripheral out of reset. The waits are counted in cycles of the block's own clock. The two parameters are sized at the defaults for a 100 MHz reference: a 100 us hold before the clock starts and a 10 ms settle before reset is released.

A configuration input says whether the peripheral has a reset line at all. Without one, an enable request just produces the clock-start command. A disable request only produces a clock-stop command and never touches the reset line. The enabled status is derived from the current clock and reset states that the surrounding register logic reports back. A peripheral held in reset always reads as not enabled. The commands are single-cycle pulses that a register bank turns into set and clear writes.

Top module: `periph_bringup_seq`

## Requirements
- R1: After reset, all four command pulses and busy_o are low.
- R2: An enable request accepted with has_rst_i=1 yields exactly one rst_assert_o pulse, then one clk_on_o pulse, then one rst_release_o pulse, each one cycle wide, with rst_assert_o in the cycle after the request was sampled.
- R3: The clk_on_o pulse of a reset-path sequence occurs exactly RST_WAIT+1 cycles after its rst_assert_o pulse (RST_WAIT >= 1).
- R4: The rst_release_o pulse occurs exactly REL_WAIT+1 cycles after the clk_on_o pulse (REL_WAIT >= 1).
- R5: An enable request accepted with has_rst_i=0 yields only a clk_on_o pulse, in the cycle after the request, and no reset pulse.
- R6: enabled_o is 1 exactly when clk_state_i=1 and not (has_rst_i=1 and rst_state_i=1).
- R7: An enable request while enabled_o=1 produces no pulse and does not raise busy_o.
- R8: A disable request produces one clk_off_o pulse in the cycle after the request and no reset pulse.
- R9: Requests arriving while busy_o=1 are ignored and change neither the pulse sequence nor its timing.
- R10: busy_o is high from the first pulse of an operation through its final pulse and is low in the cycle after the final pulse.
- R11: At most one pulse is active per cycle. When enable and disable are requested together while idle, the enable request takes precedence and the disable is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req_i | input | 1 | Enable request, sampled when idle |
| dis_req_i | input | 1 | Disable request, sampled when idle |
| has_rst_i | input | 1 | Peripheral has a reset line |
| rst_state_i | input | 1 | Peripheral reset currently asserted |
| clk_state_i | input | 1 | Peripheral clock currently running |
| rst_assert_o | output | 1 | One-cycle command: put peripheral in reset |
| rst_release_o | output | 1 | One-cycle command: take peripheral out of reset |
| clk_on_o | output | 1 | One-cycle command: start peripheral clock |
| clk_off_o | output | 1 | One-cycle command: stop peripheral clock |
| busy_o | output | 1 | An operation is in progress |
| enabled_o | output | 1 | Peripheral reported as enabled |

## Verification
The bench builds two copies side by side on the same stimulus. One uses RST_WAIT=3 and REL_WAIT=5, so the two intervals differ and a swapped or off-by-one count shows up. The other uses the minimum of 1 for both, which exercises the boundary where the countdown is loaded with zero. With such short windows, every status input combination, both enable paths, disable, simultaneous requests and requests made mid-sequence all fit in a few hundred cycles. Every pulse position can be computed arithmetically from the request cycle.

// File: rtl/periph_seq_pkg.sv
package periph_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RST_ON  = 3'd1,
    ST_HOLD_A  = 3'd2,
    ST_CLK_ON  = 3'd3,
    ST_HOLD_B  = 3'd4,
    ST_RST_OFF = 3'd5,
    ST_CLK_OFF = 3'd6
  } seq_state_e;

  // Countdown load for a hold of 'cycles' cycles (stay while count != 0)
  function automatic int unsigned hold_load(int unsigned cycles);
    return (cycles == 0) ? 0 : cycles - 1;
  endfunction

  // Counter width able to hold the larger of two wait lengths
  function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3 / R4: the countdown steps by exactly one while not reloaded
  a_r3_countdown_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4: a load is taken verbatim
  a_r4_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/periph_status.sv
module periph_status (
  input  logic has_rst_i,
  input  logic rst_state_i,
  input  logic clk_state_i,
  output logic enabled_o
);
  logic in_reset;

  assign in_reset  = has_rst_i & rst_state_i;
  assign enabled_o = clk_state_i & ~in_reset;

  // R6: a peripheral held in reset never reads as enabled
  always_comb begin
    if (has_rst_i && rst_state_i)
      a_r6_reset_hides: assert (!enabled_o);
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import periph_seq_pkg::*;
#(
  parameter int unsigned RST_WAIT = 4,
  parameter int unsigned REL_WAIT = 4,
  parameter int unsigned CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_req_i,
  input  logic          dis_req_i,
  input  logic          has_rst_i,
  input  logic          is_enabled_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          rst_assert_o,
  output logic          rst_release_o,
  output logic          clk_on_o,
  output logic          clk_off_o,
  output logic          busy_o
);
  localparam logic [CW-1:0] LOAD_A = CW'(hold_load(RST_WAIT));
  localparam logic [CW-1:0] LOAD_B = CW'(hold_load(REL_WAIT));

  seq_state_e state_q, state_d;
  logic       path_rst_q;
  logic       accept_en, accept_dis;

  // Requests only count when idle; enable wins over disable (R9, R11)
  assign accept_en  = (state_q == ST_IDLE) && en_req_i && !is_enabled_i;
  assign accept_dis = (state_q == ST_IDLE) && !en_req_i && dis_req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_en)       state_d = has_rst_i ? ST_RST_ON : ST_CLK_ON;
        else if (accept_dis) state_d = ST_CLK_OFF;
      end
      ST_RST_ON:  state_d = ST_HOLD_A;
      ST_HOLD_A:  if (tmr_zero_i) state_d = ST_CLK_ON;
      ST_CLK_ON:  state_d = path_rst_q ? ST_HOLD_B : ST_IDLE;
      ST_HOLD_B:  if (tmr_zero_i) state_d = ST_RST_OFF;
      ST_RST_OFF: state_d = ST_IDLE;
      ST_CLK_OFF: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      path_rst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_en) path_rst_q <= has_rst_i;
    end
  end

  assign tmr_load_o = (state_q == ST_RST_ON) || ((state_q == ST_CLK_ON) && path_rst_q);
  assign tmr_val_o  = (state_q == ST_RST_ON) ? LOAD_A : LOAD_B;

  assign rst_assert_o  = (state_q == ST_RST_ON);
  assign clk_on_o      = (state_q == ST_CLK_ON);
  assign rst_release_o = (state_q == ST_RST_OFF);
  assign clk_off_o     = (state_q == ST_CLK_OFF);
  assign busy_o        = (state_q != ST_IDLE);

  a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_assert_o, rst_release_o, clk_on_o, clk_off_o}));

  a_r2_clock_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_on_o && path_rst_q) |-> ($past(state_q) == ST_HOLD_A));

  a_r2_assert_then_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rst_assert_o |=> (state_q == ST_HOLD_A));

  a_r5_direct_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_on_o && !path_rst_q) |=> !busy_o);

  a_r10_release_ends: assert property (@(posedge clk) disable iff (!rst_n)
    rst_release_o |=> !busy_o);

  a_r8_off_ends: assert property (@(posedge clk) disable iff (!rst_n)
    clk_off_o |=> !busy_o);

  a_r10_starts_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (rst_assert_o || clk_on_o || clk_off_o));

  a_r7_enabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && en_req_i && is_enabled_i) |=> !busy_o);
endmodule

// File: rtl/periph_bringup_seq.sv
module periph_bringup_seq
  import periph_seq_pkg::*;
#(
  parameter int unsigned RST_WAIT = 10000,
  parameter int unsigned REL_WAIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req_i,
  input  logic dis_req_i,
  input  logic has_rst_i,
  input  logic rst_state_i,
  input  logic clk_state_i,
  output logic rst_assert_o,
  output logic rst_release_o,
  output logic clk_on_o,
  output logic clk_off_o,
  output logic busy_o,
  output logic enabled_o
);
  localparam int unsigned CW = cnt_width(RST_WAIT, REL_WAIT);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;

  periph_status u_status (
    .has_rst_i  (has_rst_i),
    .rst_state_i(rst_state_i),
    .clk_state_i(clk_state_i),
    .enabled_o  (enabled_o)
  );

  hold_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  seq_ctrl #(.RST_WAIT(RST_WAIT), .REL_WAIT(REL_WAIT), .CW(CW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_req_i     (en_req_i),
    .dis_req_i    (dis_req_i),
    .has_rst_i    (has_rst_i),
    .is_enabled_i (enabled_o),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .rst_assert_o (rst_assert_o),
    .rst_release_o(rst_release_o),
    .clk_on_o     (clk_on_o),
    .clk_off_o    (clk_off_o),
    .busy_o       (busy_o)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy_o);
endmodule

// File: tb/periph_bringup_seq_tb_top.sv
module periph_bringup_seq_tb_top;
  localparam int unsigned RW [2] = '{3, 1};
  localparam int unsigned LW [2] = '{5, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, dis = 1'b0, has_rst = 1'b0, rst_st = 1'b0, clk_st = 1'b0;
  logic ra [2], rr [2], co [2], cf [2], bz [2], ena [2];

  int cyc = 0;
  int n_checks = 0, n_fail = 0;
  int t_req = 0;
  int n_ra [2], n_rr [2], n_co [2], n_cf [2], n_bz [2];
  int t_ra [2], t_rr [2], t_co [2], t_cf [2];
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  periph_bringup_seq #(.RST_WAIT(RW[0]), .REL_WAIT(LW[0])) dut_i (
    .clk(clk), .rst_n(rst_n), .en_req_i(en), .dis_req_i(dis),
    .has_rst_i(has_rst), .rst_state_i(rst_st), .clk_state_i(clk_st),
    .rst_assert_o(ra[0]), .rst_release_o(rr[0]), .clk_on_o(co[0]),
    .clk_off_o(cf[0]), .busy_o(bz[0]), .enabled_o(ena[0]));

  periph_bringup_seq #(.RST_WAIT(RW[1]), .REL_WAIT(LW[1])) dut_b (
    .clk(clk), .rst_n(rst_n), .en_req_i(en), .dis_req_i(dis),
    .has_rst_i(has_rst), .rst_state_i(rst_st), .clk_state_i(clk_st),
    .rst_assert_o(ra[1]), .rst_release_o(rr[1]), .clk_on_o(co[1]),
    .clk_off_o(cf[1]), .busy_o(bz[1]), .enabled_o(ena[1]));

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (ra[i]) begin if (n_ra[i] == 0) t_ra[i] = cyc; n_ra[i]++; end
      if (rr[i]) begin if (n_rr[i] == 0) t_rr[i] = cyc; n_rr[i]++; end
      if (co[i]) begin if (n_co[i] == 0) t_co[i] = cyc; n_co[i]++; end
      if (cf[i]) begin if (n_cf[i] == 0) t_cf[i] = cyc; n_cf[i]++; end
      if (bz[i]) n_bz[i]++;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    for (int i = 0; i < 2; i++) begin
      n_ra[i] = 0; n_rr[i] = 0; n_co[i] = 0; n_cf[i] = 0; n_bz[i] = 0;
      t_ra[i] = -1; t_rr[i] = -1; t_co[i] = -1; t_cf[i] = -1;
    end
  endtask

  task automatic request(logic e, logic d);
    @(negedge clk);
    clear_mon();
    en = e; dis = d; t_req = cyc;
    @(negedge clk);
    en = 1'b0; dis = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    for (int i = 0; i < 2; i++) begin
      chk("R1 pulses", int'(ra[i]) + int'(rr[i]) + int'(co[i]) + int'(cf[i]), 0);
      chk("R1 busy", int'(bz[i]), 0);
    end

    // R6: status over every input combination
    for (int v = 0; v < 8; v++) begin
      has_rst = v[0]; rst_st = v[1]; clk_st = v[2];
      #1;
      chk("R6 status", int'(ena[0]), int'(v[2] && !(v[0] && v[1])));
    end

    // R2 R3 R4 R10: full sequence on both builds
    has_rst = 1; rst_st = 1; clk_st = 0;
    request(1, 0);
    for (int i = 0; i < 2; i++) begin
      chk("R2 assert count", n_ra[i], 1);
      chk("R2 clk_on count", n_co[i], 1);
      chk("R2 release count", n_rr[i], 1);
      chk("R2 clk_off count", n_cf[i], 0);
      chk("R2 assert time", t_ra[i] - t_req, 1);
      chk("R3 hold before clock", t_co[i] - t_ra[i], int'(RW[i]) + 1);
      chk("R4 hold before release", t_rr[i] - t_co[i], int'(LW[i]) + 1);
      chk("R10 busy length", n_bz[i], int'(RW[i] + LW[i]) + 3);
    end

    // R5: no reset line
    has_rst = 0; rst_st = 1; clk_st = 0;
    request(1, 0);
    for (int i = 0; i < 2; i++) begin
      chk("R5 clk_on count", n_co[i], 1);
      chk("R5 clk_on time", t_co[i] - t_req, 1);
      chk("R5 no reset pulses", n_ra[i] + n_rr[i], 0);
      chk("R5 busy length", n_bz[i], 1);
    end

    // R7: already enabled, with and without a reset line
    for (int k = 0; k < 2; k++) begin
      has_rst = k[0]; rst_st = !k[0]; clk_st = 1;
      request(1, 0);
      for (int i = 0; i < 2; i++) begin
        chk("R7 no pulses", n_ra[i] + n_rr[i] + n_co[i] + n_cf[i], 0);
        chk("R7 no busy", n_bz[i], 0);
      end
    end

    // R8: disable only stops the clock
    has_rst = 1; rst_st = 0; clk_st = 1;
    request(0, 1);
    for (int i = 0; i < 2; i++) begin
      chk("R8 clk_off count", n_cf[i], 1);
      chk("R8 clk_off time", t_cf[i] - t_req, 1);
      chk("R8 no reset pulses", n_ra[i] + n_rr[i] + n_co[i], 0);
    end

    // R11: enable and disable together, enable wins
    has_rst = 0; rst_st = 0; clk_st = 0;
    request(1, 1);
    for (int i = 0; i < 2; i++) begin
      chk("R11 clk_on count", n_co[i], 1);
      chk("R11 clk_off dropped", n_cf[i], 0);
    end

    // R9: requests during a sequence are ignored
    has_rst = 1; rst_st = 1; clk_st = 0;
    @(negedge clk);
    clear_mon();
    en = 1; t_req = cyc;
    @(negedge clk); en = 0;
    @(negedge clk); en = 1; dis = 1;
    @(negedge clk); en = 0; dis = 0;
    @(negedge clk); dis = 1;
    @(negedge clk); dis = 0;
    repeat (20) @(negedge clk);
    chk("R9 single assert", n_ra[0], 1);
    chk("R9 single clk_on", n_co[0], 1);
    chk("R9 single release", n_rr[0], 1);
    chk("R9 no clk_off", n_cf[0], 0);
    chk("R9 timing kept", t_rr[0] - t_req, int'(RW[0] + LW[0]) + 3);
    chk("R9 busy length", n_bz[0], int'(RW[0] + LW[0]) + 3);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule